// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block steps a processor core through one coprocessor instruction. Five kinds are supported: a register move to the coprocessor, a register move back from it, an internal coprocessor operation, and multi-word loads and stores between memory and the coprocessor. The sequencer presents a request code to the external coprocessor and decides what to do next from the two-bit response it receives in the same cycle. For loads and stores it also drives word-aligned memory addresses.

While the coprocessor reports that it is busy, the sequencer spends one internal cycle per retry. In that cycle it checks the pending reset, fast interrupt and normal interrupt lines. If one of them is pending and not masked, it sends an abandon request and ends the instruction with an interrupt outcome. Every instruction ends with exactly one single-cycle outcome pulse: done, undefined instruction, coprocessor abort, address exception, data abort or interrupt. Exception entry is left to the surrounding core.

Top module: `cp_handshake_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_o` is NONE (0), `busy_o` is 0 and every outcome pulse is 0. At most one outcome pulse is high in any cycle.
- R2: A `start_i` sampled while idle makes the next cycle present request FIRST (1). Response codes are GO 2'b00, BUSY 2'b01, CANT 2'b10 and INC 2'b11. For an internal operation (op 2), a GO reply gives `done_o` high for one cycle in the following cycle, and `busy_o` is then 0.
- R3: Each BUSY reply is followed by one internal cycle (`cyc_o` = 1) with request NONE. The cycle after that presents request BUSY (2), and its reply is handled like a reply to FIRST.
- R4: If an unmasked interrupt is pending during the internal cycle of a busy-wait, that cycle presents request INTR (3). The next cycle pulses `intr_o` with no `done_o`. If nothing is pending, the retry goes ahead.
- R5: The interrupt kind is 0 for reset, 1 for the fast interrupt and 2 for the normal interrupt, taken in that priority. The fast interrupt counts only when `f_mask_i` is 0, and the normal interrupt only when `i_mask_i` is 0.
- R6: A CANT reply to a register move or an internal operation pulses `undef_o`. A CANT reply to a load (op 3) or a store (op 4) pulses `cp_abort_o` instead.
- R7: After GO or INC, a load or store runs memory cycles (`cyc_o` = 3, `mem_req_o` = 1, request DATA 4). The first address is `addr_i` with its two low bits cleared. Each INC reply adds 4 to the address and runs one more word. A GO reply ends the transfer with `done_o`. `mem_we_o` is 1 only for stores.
- R8: A load or store starts with `addr_i` at or above 2^LIM_BITS, or a store starts with `addr_i` below VEC_BYTES. In either case the next cycle pulses `addr_exc_o` and no request is ever presented.
- R9: A register read (op 1) ending in CANT sets `rd_data_o` to `flags_i` in its top four bits and zeros below.
- R10: A successful register move spends one coprocessor cycle (`cyc_o` = 2, request DATA). A read captures `cp_data_i` in that cycle and then adds one internal cycle before `done_o`. A write ends with `done_o` in the cycle right after.
- R11: A `data_abort_i` seen in any memory cycle of a transfer is held. The transfer then ends with `data_abort_o` instead of `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction (sampled while idle) |
| op_i | input | 3 | Kind: 0 write reg, 1 read reg, 2 internal op, 3 load, 4 store |
| addr_i | input | AW | Start address for load/store |
| flags_i | input | 4 | Condition flags returned by a failed read |
| resp_i | input | 2 | Coprocessor response |
| cp_data_i | input | DW | Register value from the coprocessor |
| rst_pend_i | input | 1 | Reset pending |
| fiq_i | input | 1 | Fast interrupt pending |
| irq_i | input | 1 | Normal interrupt pending |
| f_mask_i | input | 1 | Fast interrupt masked |
| i_mask_i | input | 1 | Normal interrupt masked |
| data_abort_i | input | 1 | Memory abort for the current word |
| req_o | output | 3 | Request code: 0 none, 1 first, 2 busy, 3 intr, 4 data |
| cyc_o | output | 2 | Cycle type: 0 none, 1 internal, 2 coprocessor, 3 memory |
| mem_req_o | output | 1 | Memory word access this cycle |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | AW | Word address |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Normal completion pulse |
| rd_data_o | output | DW | Result of a register read |
| undef_o | output | 1 | Undefined-instruction pulse |
| cp_abort_o | output | 1 | Coprocessor abort pulse |
| addr_exc_o | output | 1 | Address exception pulse |
| data_abort_o | output | 1 | Data abort pulse |
| intr_o | output | 1 | Abandoned for interrupt pulse |
| intr_kind_o | output | 2 | Kind of interrupt taken |

## Verification
The tests use replies of zero, one and two BUSY before GO, so an off-by-one in the retry loop shows up in the cycle count. Interrupt tests are driven in the busy-wait with all three lines raised, with the fast line masked, and with both lines masked. These patterns separate priority order, masking, and the case where nothing is taken. Bursts start from an unaligned address and run one or three words, which checks both the alignment and the step size. The range tests cover a high address, a store into the vector area, and a load at that same low address that must still go ahead.

// File: rtl/cp_seq_pkg.sv
package cp_seq_pkg;
  typedef enum logic [2:0] {
    OP_TO_CP = 3'd0, OP_FROM_CP = 3'd1, OP_EXEC = 3'd2, OP_LOAD = 3'd3, OP_STORE = 3'd4
  } op_e;
  typedef enum logic [1:0] {
    RSP_GO = 2'b00, RSP_BUSY = 2'b01, RSP_CANT = 2'b10, RSP_INC = 2'b11
  } rsp_e;
  typedef enum logic [2:0] {
    REQ_NONE = 3'd0, REQ_FIRST = 3'd1, REQ_BUSY = 3'd2, REQ_INTR = 3'd3, REQ_DATA = 3'd4
  } req_e;
  typedef enum logic [1:0] {
    CYC_NONE = 2'd0, CYC_INT = 2'd1, CYC_COP = 2'd2, CYC_MEM = 2'd3
  } cyc_e;
  typedef enum logic [1:0] {
    IK_RESET = 2'd0, IK_FAST = 2'd1, IK_NORM = 2'd2
  } ikind_e;
endpackage

// File: rtl/cp_seq_irq_pick.sv
module cp_seq_irq_pick
  import cp_seq_pkg::*;
(
  input  logic   rst_pend_i,
  input  logic   fiq_i,
  input  logic   irq_i,
  input  logic   f_mask_i,
  input  logic   i_mask_i,
  output logic   pend_o,
  output ikind_e kind_o
);
  logic fast_ok, norm_ok;
  assign fast_ok = fiq_i & ~f_mask_i;
  assign norm_ok = irq_i & ~i_mask_i;
  assign pend_o  = rst_pend_i | fast_ok | norm_ok;

  always_comb begin
    if (rst_pend_i)   kind_o = IK_RESET;
    else if (fast_ok) kind_o = IK_FAST;
    else              kind_o = IK_NORM;
  end
endmodule

// File: rtl/cp_seq_addr_gen.sv
module cp_seq_addr_gen #(
  parameter int AW        = 32,
  parameter int LIM_BITS  = 26,
  parameter int VEC_BYTES = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          is_store_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          range_err_o
);
  localparam logic [AW-1:0] WORD_STEP = AW'(4);
  localparam logic [AW-1:0] VEC_TOP   = AW'(VEC_BYTES);

  logic [AW-1:0] addr_q;
  logic          too_high;

  generate
    if (LIM_BITS < AW) begin : g_lim
      assign too_high = |addr_i[AW-1:LIM_BITS];
    end else begin : g_nolim
      assign too_high = 1'b0;
    end
  endgenerate

  assign range_err_o = too_high | (is_store_i && (addr_i < VEC_TOP));
  assign addr_o      = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= {addr_i[AW-1:2], 2'b00};
    else if (step_i) addr_q <= addr_q + WORD_STEP;
  end
endmodule

// File: rtl/cp_handshake_seq.sv
module cp_handshake_seq
  import cp_seq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LIM_BITS  = 26,
  parameter int VEC_BYTES = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    flags_i,
  input  logic [1:0]    resp_i,
  input  logic [DW-1:0] cp_data_i,
  input  logic          rst_pend_i,
  input  logic          fiq_i,
  input  logic          irq_i,
  input  logic          f_mask_i,
  input  logic          i_mask_i,
  input  logic          data_abort_i,
  output logic [2:0]    req_o,
  output logic [1:0]    cyc_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rd_data_o,
  output logic          undef_o,
  output logic          cp_abort_o,
  output logic          addr_exc_o,
  output logic          data_abort_o,
  output logic          intr_o,
  output logic [1:0]    intr_kind_o
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_FIRST, ST_WAIT, ST_POLL, ST_XFER, ST_COP, ST_TAIL
  } state_e;

  state_e state_q, state_d;
  op_e    op_q, op_in;
  rsp_e   rsp;
  req_e   req;
  cyc_e   cyc;
  ikind_e pick_kind, kind_q;
  logic   pend, range_err, addr_load, addr_step, in_is_mem, q_is_mem;
  logic   cap_data, cap_flags, abort_q;
  logic   ev_done, ev_undef, ev_cpab, ev_aexc, ev_dab, ev_intr;
  logic   done_q, undef_q, cpab_q, aexc_q, dab_q, intr_q;
  logic [DW-1:0] rd_q;

  assign op_in     = op_e'(op_i);
  assign rsp       = rsp_e'(resp_i);
  assign in_is_mem = (op_in == OP_LOAD) || (op_in == OP_STORE);
  assign q_is_mem  = (op_q == OP_LOAD) || (op_q == OP_STORE);

  cp_seq_irq_pick i_pick (
    .rst_pend_i(rst_pend_i), .fiq_i(fiq_i), .irq_i(irq_i),
    .f_mask_i(f_mask_i), .i_mask_i(i_mask_i),
    .pend_o(pend), .kind_o(pick_kind)
  );

  cp_seq_addr_gen #(.AW(AW), .LIM_BITS(LIM_BITS), .VEC_BYTES(VEC_BYTES)) i_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(addr_load), .step_i(addr_step),
    .is_store_i(op_in == OP_STORE), .addr_i(addr_i),
    .addr_o(mem_addr_o), .range_err_o(range_err)
  );

  always_comb begin
    state_d   = state_q;
    req       = REQ_NONE;
    cyc       = CYC_NONE;
    mem_req_o = 1'b0;
    addr_load = 1'b0;
    addr_step = 1'b0;
    cap_data  = 1'b0;
    cap_flags = 1'b0;
    ev_done = 1'b0; ev_undef = 1'b0; ev_cpab = 1'b0;
    ev_aexc = 1'b0; ev_dab = 1'b0;   ev_intr = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        addr_load = 1'b1;
        if (in_is_mem && range_err) ev_aexc = 1'b1;
        else state_d = ST_FIRST;
      end
      ST_FIRST, ST_POLL: begin
        req = (state_q == ST_FIRST) ? REQ_FIRST : REQ_BUSY;
        cyc = CYC_COP;
        unique case (rsp)
          RSP_BUSY: state_d = ST_WAIT;
          RSP_CANT: begin
            state_d   = ST_IDLE;
            ev_cpab   = q_is_mem;
            ev_undef  = !q_is_mem;
            cap_flags = (op_q == OP_FROM_CP);
          end
          default: begin
            if (q_is_mem) state_d = ST_XFER;
            else if ((op_q == OP_TO_CP) || (op_q == OP_FROM_CP)) state_d = ST_COP;
            else begin
              state_d = ST_IDLE;
              ev_done = 1'b1;
            end
          end
        endcase
      end
      ST_WAIT: begin
        cyc = CYC_INT;
        if (pend) begin
          req     = REQ_INTR;
          ev_intr = 1'b1;
          state_d = ST_IDLE;
        end else state_d = ST_POLL;
      end
      ST_XFER: begin
        cyc       = CYC_MEM;
        req       = REQ_DATA;
        mem_req_o = 1'b1;
        if (rsp == RSP_INC) addr_step = 1'b1;
        else begin
          state_d = ST_IDLE;
          ev_dab  = abort_q | data_abort_i;
          ev_done = !(abort_q | data_abort_i);
        end
      end
      ST_COP: begin
        cyc = CYC_COP;
        req = REQ_DATA;
        if (op_q == OP_FROM_CP) begin
          cap_data = 1'b1;
          state_d  = ST_TAIL;
        end else begin
          ev_done = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_TAIL: begin
        cyc     = CYC_INT;
        ev_done = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_EXEC;
      abort_q <= 1'b0;
      rd_q    <= '0;
      kind_q  <= IK_RESET;
      {done_q, undef_q, cpab_q, aexc_q, dab_q, intr_q} <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        op_q    <= op_in;
        abort_q <= 1'b0;
      end else if (state_q == ST_XFER && data_abort_i) begin
        abort_q <= 1'b1;
      end
      if (cap_data)       rd_q <= cp_data_i;
      else if (cap_flags) rd_q <= {flags_i, {(DW-4){1'b0}}};
      if (ev_intr) kind_q <= pick_kind;
      {done_q, undef_q, cpab_q, aexc_q, dab_q, intr_q} <=
        {ev_done, ev_undef, ev_cpab, ev_aexc, ev_dab, ev_intr};
    end
  end

  assign req_o        = req;
  assign cyc_o        = cyc;
  assign mem_we_o     = mem_req_o && (op_q == OP_STORE);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign undef_o      = undef_q;
  assign cp_abort_o   = cpab_q;
  assign addr_exc_o   = aexc_q;
  assign data_abort_o = dab_q;
  assign intr_o       = intr_q;
  assign intr_kind_o  = kind_q;
  assign rd_data_o    = rd_q;
endmodule

// File: rtl/cp_seq_chk.sv
module cp_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    req_o,
  input logic [1:0]    cyc_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          undef_o,
  input logic          cp_abort_o,
  input logic          addr_exc_o,
  input logic          data_abort_o,
  input logic          intr_o
);
  // R1
  outcome_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, undef_o, cp_abort_o, addr_exc_o, data_abort_o, intr_o}));

  // R3
  busy_after_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o == 3'd2) |-> ($past(cyc_o) == 2'd1));

  // R4
  intr_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o == 3'd3) |=> (intr_o && !done_o));

  // R7
  word_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  // R7
  burst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> (mem_addr_o == $past(mem_addr_o) + AW'(4)));

  // R8
  aexc_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_exc_o |-> (!$past(busy_o) && !busy_o));
endmodule

bind cp_handshake_seq cp_seq_chk #(.AW(AW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_o(req_o), .cyc_o(cyc_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .busy_o(busy_o),
  .done_o(done_o), .undef_o(undef_o), .cp_abort_o(cp_abort_o),
  .addr_exc_o(addr_exc_o), .data_abort_o(data_abort_o), .intr_o(intr_o)
);

// File: tb/test_cp_handshake_seq.sv
`timescale 1ns/1ps
module test_cp_handshake_seq;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [3:0] flags_i = '0;
  logic [1:0] resp_i = 2'b00;
  logic [DW-1:0] cp_data_i = '0;
  logic rst_pend_i = 0, fiq_i = 0, irq_i = 0, f_mask_i = 0, i_mask_i = 0, data_abort_i = 0;
  logic [2:0] req_o;
  logic [1:0] cyc_o, intr_kind_o;
  logic mem_req_o, mem_we_o, busy_o, done_o, undef_o, cp_abort_o, addr_exc_o, data_abort_o, intr_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] rd_data_o;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cp_handshake_seq i_cp_handshake_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
    .flags_i(flags_i), .resp_i(resp_i), .cp_data_i(cp_data_i), .rst_pend_i(rst_pend_i),
    .fiq_i(fiq_i), .irq_i(irq_i), .f_mask_i(f_mask_i), .i_mask_i(i_mask_i),
    .data_abort_i(data_abort_i), .req_o(req_o), .cyc_o(cyc_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .busy_o(busy_o), .done_o(done_o),
    .rd_data_o(rd_data_o), .undef_o(undef_o), .cp_abort_o(cp_abort_o),
    .addr_exc_o(addr_exc_o), .data_abort_o(data_abort_o), .intr_o(intr_o),
    .intr_kind_o(intr_kind_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic go(input logic [2:0] op, input logic [AW-1:0] a);
    start_i = 1'b1; op_i = op; addr_i = a;
    tick();
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    tick();
    chk("R1 req in reset", 32'(req_o), 0);
    chk("R1 busy in reset", 32'(busy_o), 0);
    chk("R1 pulses in reset", 32'({done_o, undef_o, cp_abort_o, addr_exc_o, data_abort_o, intr_o}), 0);
    rst_ni = 1'b1;
    tick();
    chk("R1 req after reset", 32'(req_o), 0);
    chk("R1 busy after reset", 32'(busy_o), 0);
  endtask

  task automatic t_exec_go();
    go(3'd2, '0);
    chk("R2 first request", 32'(req_o), 1);
    resp_i = 2'b00;
    tick();
    chk("R2 done", 32'(done_o), 1);
    chk("R2 idle after", 32'(busy_o), 0);
    tick();
    chk("R2 done one cycle", 32'(done_o), 0);
  endtask

  task automatic t_busy_twice();
    go(3'd2, '0);
    resp_i = 2'b01;
    tick();
    chk("R3 idle cycle type", 32'(cyc_o), 1);
    chk("R3 idle request", 32'(req_o), 0);
    tick();
    chk("R3 retry request", 32'(req_o), 2);
    resp_i = 2'b01;
    tick();
    chk("R3 second idle", 32'(cyc_o), 1);
    tick();
    chk("R3 second retry", 32'(req_o), 2);
    resp_i = 2'b00;
    tick();
    chk("R3 done after retries", 32'(done_o), 1);
    tick();
  endtask

  task automatic t_intr(input logic r, input logic f, input logic i, input logic fm,
                        input logic im, input logic take, input logic [1:0] kind);
    go(3'd2, '0);
    resp_i = 2'b01;
    rst_pend_i = r; fiq_i = f; irq_i = i; f_mask_i = fm; i_mask_i = im;
    tick();
    chk("R4 wait request", 32'(req_o), take ? 3 : 0);
    tick();
    rst_pend_i = 0; fiq_i = 0; irq_i = 0; f_mask_i = 0; i_mask_i = 0;
    if (take) begin
      chk("R4 intr pulse", 32'(intr_o), 1);
      chk("R4 no done", 32'(done_o), 0);
      chk("R5 intr kind", 32'(intr_kind_o), 32'(kind));
    end else begin
      chk("R5 masked retries", 32'(req_o), 2);
      resp_i = 2'b00;
      tick();
      chk("R5 masked done", 32'(done_o), 1);
    end
    resp_i = 2'b00;
    tick();
  endtask

  task automatic t_cant();
    go(3'd0, '0);
    resp_i = 2'b10;
    tick();
    chk("R6 undef on write", 32'(undef_o), 1);
    chk("R6 no cp abort", 32'(cp_abort_o), 0);
    tick();
    go(3'd3, 32'h100);
    resp_i = 2'b10;
    tick();
    chk("R6 cp abort on load", 32'(cp_abort_o), 1);
    chk("R6 no undef on load", 32'(undef_o), 0);
    resp_i = 2'b00;
    tick();
  endtask

  task automatic t_regs();
    go(3'd1, '0);
    resp_i = 2'b00;
    tick();
    chk("R10 read cop cycle", 32'(cyc_o), 2);
    chk("R10 read data req", 32'(req_o), 4);
    cp_data_i = 32'hCAFE_1234;
    tick();
    cp_data_i = '0;
    chk("R10 read extra idle", 32'(cyc_o), 1);
    chk("R10 not done yet", 32'(done_o), 0);
    tick();
    chk("R10 read done", 32'(done_o), 1);
    chk("R10 read value", rd_data_o, 32'hCAFE_1234);
    go(3'd0, '0);
    tick();
    chk("R10 write cop cycle", 32'(cyc_o), 2);
    tick();
    chk("R10 write done", 32'(done_o), 1);
    flags_i = 4'hA;
    go(3'd1, '0);
    resp_i = 2'b10;
    tick();
    flags_i = 4'h0;
    chk("R9 read cant undef", 32'(undef_o), 1);
    chk("R9 flags returned", rd_data_o, 32'hA000_0000);
    resp_i = 2'b00;
    tick();
  endtask

  task automatic t_bursts();
    go(3'd3, 32'h103);
    resp_i = 2'b00;
    tick();
    chk("R7 first word addr", mem_addr_o, 32'h100);
    chk("R7 load is read", 32'({mem_req_o, mem_we_o, cyc_o}), 32'b1011);
    resp_i = 2'b11;
    tick();
    chk("R7 second word addr", mem_addr_o, 32'h104);
    resp_i = 2'b11;
    tick();
    chk("R7 third word addr", mem_addr_o, 32'h108);
    resp_i = 2'b00;
    tick();
    chk("R7 burst done", 32'(done_o), 1);
    chk("R7 mem idle", 32'(mem_req_o), 0);
    go(3'd4, 32'h200);
    resp_i = 2'b11;
    tick();
    chk("R7 store write", 32'({mem_req_o, mem_we_o}), 3);
    chk("R7 store addr", mem_addr_o, 32'h200);
    resp_i = 2'b00;
    tick();
    chk("R7 store done", 32'(done_o), 1);
  endtask

  task automatic t_range();
    go(3'd3, 32'h0400_0000);
    chk("R8 high load exc", 32'(addr_exc_o), 1);
    chk("R8 no request", 32'({busy_o, req_o}), 0);
    go(3'd4, 32'h1C);
    chk("R8 vector store exc", 32'(addr_exc_o), 1);
    go(3'd3, 32'h1C);
    chk("R8 vector load allowed", 32'({addr_exc_o, req_o}), 1);
    resp_i = 2'b10;
    tick();
    resp_i = 2'b00;
    tick();
  endtask

  task automatic t_dabort();
    go(3'd3, 32'h40);
    resp_i = 2'b00;
    tick();
    data_abort_i = 1'b1;
    resp_i = 2'b11;
    tick();
    data_abort_i = 1'b0;
    resp_i = 2'b00;
    tick();
    chk("R11 data abort reported", 32'(data_abort_o), 1);
    chk("R11 no done", 32'(done_o), 0);
    tick();
  endtask

  initial begin
    t_reset();
    t_exec_go();
    t_busy_twice();
    t_intr(1, 1, 1, 0, 0, 1, 2'd0);
    t_intr(0, 1, 1, 0, 0, 1, 2'd1);
    t_intr(0, 1, 1, 1, 0, 1, 2'd2);
    t_intr(0, 1, 1, 1, 1, 0, 2'd0);
    t_cant();
    t_regs();
    t_bursts();
    t_range();
    t_dabort();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule